// File: doc/BRIEF.md
# Extended-Precision Float to Signed Integer Converter (Chop)

This block turns an 80-bit extended-precision floating-point operand into a signed integer of 16, 32 or 64 bits. Rounding is always toward zero, whatever rounding mode is set elsewhere in the machine. The result is registered one clock after the request and is always presented sign-extended to 64 bits. The block also reports an invalid-operation flag, a stack-fault flag, a precision (inexact) flag and a condition bit.

The operand has 1 sign bit at bit 79, a 15-bit biased exponent in bits 78:64 with bias 16383, and a 64-bit significand in bits 63:0 with an explicit integer bit. An exponent of all ones stands for an infinity or a NaN. An exponent of zero stands for zero or a denormal. A separate empty flag marks a missing source operand, which is a stack underflow. Storing the result and popping the stack belong to the surrounding pipeline.

Top module: `ftoi_chop`

## Requirements
- R1: After reset, out_valid, out_int, out_invalid, out_stack_fault, out_precision and out_c1 are all 0.
- R2: A request with in_valid=1 at one rising edge gives out_valid=1 after that edge. out_valid is 0 after any edge where in_valid was 0.
- R3: in_size selects the destination width: 0 is 16 bits, 1 is 32 bits, 2 or 3 is 64 bits. out_int is the result sign-extended to 64 bits.
- R4: Finite values truncate toward zero. An operand that is already an integer and is in range passes through exactly.
- R5: Any value whose magnitude is strictly below 1 gives 0, and this includes every denormal.
- R6: out_precision is 1 exactly when a valid conversion discards a nonzero fraction.
- R7: The range check accepts the most negative value of the width, for example -32768 at 16 bits. It rejects +32768 and any larger magnitude, and raises out_invalid.
- R8: An infinity (exponent all ones, significand 0x8000000000000000) of either sign raises out_invalid.
- R9: Any NaN (exponent all ones, any other significand) raises out_invalid.
- R10: in_empty=1 raises both out_invalid and out_stack_fault. out_stack_fault is 0 in every other case.
- R11: Whenever out_invalid is 1, out_int holds the most negative value of the selected width, sign-extended. out_precision is then 0.
- R12: out_c1 is 0 for every conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request |
| in_empty | input | 1 | Source operand missing (stack underflow) |
| in_op | input | 80 | Extended-precision operand |
| in_size | input | 2 | Destination width select |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_int | output | 64 | Truncated integer, sign-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_stack_fault | output | 1 | Stack underflow indication |
| out_precision | output | 1 | Inexact result flag |
| out_c1 | output | 1 | Condition bit, cleared by each conversion |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent and a 64-bit significand, which is the full 80-bit format. Every size select is covered, including 3. For each one the bench sweeps integer parts around 2^15, 2^31 and 2^63 with both signs and with no fraction, a half fraction or a quarter fraction. This puts each width's limits within reach, including the asymmetric negative bound and the all-ones 64-bit magnitude. Denormals, the two infinities, quiet and signalling NaNs and the empty-operand case are added at every width.

// File: rtl/ftoi_chop.sv
module ftoi_chop #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_empty,
  input  logic [EXP_W+SIG_W:0]       in_op,
  input  logic [1:0]                 in_size,
  output logic                       out_valid,
  output logic [SIG_W-1:0]           out_int,
  output logic                       out_invalid,
  output logic                       out_stack_fault,
  output logic                       out_precision,
  output logic                       out_c1
);
  localparam int IN_W = 1 + EXP_W + SIG_W;
  localparam int SHW  = $clog2(SIG_W);
  localparam int UEW  = EXP_W + 2;
  localparam logic signed [UEW-1:0] BIAS = UEW'((1 << (EXP_W-1)) - 1);

  logic                   sgn;
  logic [EXP_W-1:0]       ex;
  logic [SIG_W-1:0]       sig;
  logic signed [UEW-1:0]  ue;
  logic                   ex_max, tiny, big, lost, ovf, inv, prec;
  logic [SHW-1:0]         sh;
  logic [SIG_W-1:0]       mag, lim_pos, value;
  int unsigned            width;
  logic [1:0]             sz_q;

  assign sgn    = in_op[IN_W-1];
  assign ex     = in_op[IN_W-2 -: EXP_W];
  assign sig    = in_op[SIG_W-1:0];
  assign ue     = $signed({2'b00, ex}) - BIAS;
  assign ex_max = &ex;
  assign tiny   = ue < 0;
  assign big    = ue >= UEW'(SIG_W);
  assign sh     = SHW'(SIG_W-1) - ue[SHW-1:0];
  assign mag    = sig >> sh;
  assign lost   = (mag << sh) != sig;

  always_comb begin
    case (in_size)
      2'd0:    width = 16;
      2'd1:    width = 32;
      default: width = SIG_W;
    endcase
  end

  assign lim_pos = (SIG_W'(1) << (width - 1)) - SIG_W'(1);
  assign ovf     = sgn ? (mag > lim_pos + SIG_W'(1)) : (mag > lim_pos);
  assign inv     = in_empty | ex_max | (!tiny & (big | ovf));
  assign prec    = !inv & (tiny ? (sig != '0) : lost);
  assign value   = inv ? ~lim_pos : tiny ? '0 : sgn ? (~mag + SIG_W'(1)) : mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_int         <= '0;
      out_invalid     <= 1'b0;
      out_stack_fault <= 1'b0;
      out_precision   <= 1'b0;
      out_c1          <= 1'b0;
      sz_q            <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int         <= value;
        out_invalid     <= inv;
        out_stack_fault <= in_empty;
        out_precision   <= prec;
        out_c1          <= 1'b0;
        sz_q            <= in_size;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_FIT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && sz_q == 2'd0) |->
      ((&out_int[SIG_W-1:15]) || !(|out_int[SIG_W-1:15]))); // R3
  AST_FIT_32: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && sz_q == 2'd1) |->
      ((&out_int[SIG_W-1:31]) || !(|out_int[SIG_W-1:31]))); // R3
  AST_EMPTY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_empty) |=> (out_stack_fault && out_invalid)); // R10
  AST_FAULT_IMPLIES_INV: assert property (@(posedge clk) disable iff (!rst_n)
    out_stack_fault |-> out_invalid); // R10
  AST_INV_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |->
      (out_int == ({SIG_W{1'b1}} << ((sz_q == 2'd0) ? 15 : (sz_q == 2'd1) ? 31 : SIG_W-1)))); // R11
  AST_INV_NO_PREC: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> !out_precision); // R11
  AST_NAN_INF_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_op[IN_W-2 -: EXP_W])) |=> out_invalid); // R8
  AST_C1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_c1); // R12
endmodule

// File: tb/ftoi_chop_bench.sv
module ftoi_chop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_empty = 1'b0;
  logic [79:0] in_op = '0;
  logic [1:0]  in_size = 2'd0;
  logic        out_valid;
  logic [63:0] out_int;
  logic        out_invalid, out_stack_fault, out_precision, out_c1;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ftoi_chop u_ftoi_chop (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_empty(in_empty),
    .in_op(in_op), .in_size(in_size), .out_valid(out_valid), .out_int(out_int),
    .out_invalid(out_invalid), .out_stack_fault(out_stack_fault),
    .out_precision(out_precision), .out_c1(out_c1)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] build(input bit s, input logic [63:0] k, input logic [63:0] f);
    logic [127:0] fx;
    logic [127:0] nrm;
    int p;
    fx = {k, f};
    p = -1;
    for (int i = 0; i < 128; i++) if (fx[i]) p = i;
    if (p < 0) return {s, 79'd0};
    nrm = fx << (127 - p);
    return {s, 15'(16383 + p - 64), nrm[127:64]};
  endfunction

  function automatic int wid(input logic [1:0] sz);
    return (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
  endfunction

  task automatic run(input logic [79:0] op, input logic [1:0] sz, input bit emp,
                     input logic [63:0] e_int, input bit e_inv, input bit e_stk,
                     input bit e_prec, input string req);
    @(negedge clk);
    in_op = op; in_size = sz; in_empty = emp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " / R2 valid"}, 64'(out_valid), 64'd1);
    check({req, " value"}, out_int, e_int);
    check({req, " / R11 invalid"}, 64'(out_invalid), 64'(e_inv));
    check({req, " / R10 stack fault"}, 64'(out_stack_fault), 64'(e_stk));
    check({req, " / R6 precision"}, 64'(out_precision), 64'(e_prec));
    check({req, " / R12 c1"}, 64'(out_c1), 64'd0);
  endtask

  task automatic case_kf(input bit s, input logic [63:0] k, input logic [63:0] f, input logic [1:0] sz);
    int w;
    logic [63:0] lim, indef, ev;
    bit inv;
    string rq;
    w = wid(sz);
    lim = 64'd1 << (w - 1);
    indef = ~(lim - 64'd1);
    inv = s ? (k > lim) : (k >= lim);
    ev = inv ? indef : (s ? (~k + 64'd1) : k);
    rq = inv ? "R7" : (k == 0 ? "R5" : (f != 0 ? "R4" : "R3"));
    run(build(s, k, f), sz, 1'b0, ev, inv, 1'b0, !inv && (f != 0), rq);
  endtask

  initial begin
    logic [63:0] ks[16];
    logic [63:0] fs[3];
    fs[0] = 64'd0; fs[1] = 64'h8000_0000_0000_0000; fs[2] = 64'h4000_0000_0000_0000;
    ks[0] = 0; ks[1] = 1; ks[2] = 2; ks[3] = 3; ks[4] = 100;
    ks[5] = 64'h7FFF; ks[6] = 64'h8000; ks[7] = 64'h8001;
    ks[8] = 64'h7FFF_FFFF; ks[9] = 64'h8000_0000; ks[10] = 64'h8000_0001;
    ks[11] = 64'h7FFF_FFFF_FFFF_FFFF; ks[12] = 64'h8000_0000_0000_0000;
    ks[13] = 64'h8000_0000_0000_0001; ks[14] = 64'hFFFF_FFFF_FFFF_FFFF;
    ks[15] = 64'h1234_5678;

    repeat (3) @(negedge clk);
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 int", out_int, 64'd0);
    check("R1 invalid", 64'(out_invalid), 64'd0);
    check("R1 stack", 64'(out_stack_fault), 64'd0);
    check("R1 precision", 64'(out_precision), 64'd0);
    check("R1 c1", 64'(out_c1), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", 64'(out_valid), 64'd0);

    for (int sz = 0; sz < 4; sz++) begin
      int w;
      logic [63:0] indef;
      w = wid(2'(sz));
      indef = ~((64'd1 << (w - 1)) - 64'd1);
      for (int ki = 0; ki < 16; ki++)
        for (int fi = 0; fi < 3; fi++)
          for (int s = 0; s < 2; s++)
            if (fi == 0 || ks[ki] < 64'h4000_0000_0000_0000)
              case_kf(s[0], ks[ki], fs[fi], 2'(sz));
      run({1'b0, 15'd0, 64'h0000_0000_0000_0001}, 2'(sz), 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, "R5 denormal");
      run({1'b1, 15'd0, 64'h7FFF_FFFF_FFFF_FFFF}, 2'(sz), 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, "R5 neg denormal");
      run({1'b0, 15'd16382, 64'hFFFF_FFFF_FFFF_FFFF}, 2'(sz), 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, "R5 below one");
      run({1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'(sz), 1'b0, indef, 1'b1, 1'b0, 1'b0, "R8 +inf");
      run({1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'(sz), 1'b0, indef, 1'b1, 1'b0, 1'b0, "R8 -inf");
      run({1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 2'(sz), 1'b0, indef, 1'b1, 1'b0, 1'b0, "R9 qnan");
      run({1'b1, 15'h7FFF, 64'h8000_0000_0000_0001}, 2'(sz), 1'b0, indef, 1'b1, 1'b0, 1'b0, "R9 snan");
      run({1'b0, 15'd20000, 64'h8000_0000_0000_0000}, 2'(sz), 1'b0, indef, 1'b1, 1'b0, 1'b0, "R7 huge");
      run(build(1'b0, 64'd5, 64'h8000_0000_0000_0000), 2'(sz), 1'b1, indef, 1'b1, 1'b1, 1'b0, "R10 empty");
    end

    @(negedge clk);
    check("R2 drop", 64'(out_valid), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          tests++; fails++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
      wait (done);
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule